// File: doc/BRIEF.md
# Power Mode and Address Strobe Controller

This block governs the low-power states of a small 8-bit controller core and produces the address-latch strobe pin. Software in the core writes a two-bit power mode field. One bit puts the core into idle: the core clock enable drops, while the peripherals (interrupt logic, timers, serial port) keep their clock enable. The other bit puts the whole device into power down, where both clock enables drop. A pending enabled interrupt ends idle. Power down ends only through a reset on the external reset pin. That pin is trusted only once it has stayed high for two machine cycles of twelve oscillator clocks each.

While the core runs, the address strobe pulses at one sixth of the oscillator rate. A configuration bit silences the strobe to reduce emissions. In idle the strobe and the active-low fetch enable pin are both held high. In power down both are driven low. The qualified reset output goes to the rest of the chip. The same reset returns this block to the running state with the silencing bit cleared.

Top module: `pmc_power_ctrl`

## Requirements
- R1: After the synchronous `rst`, the mode field reads 00, the silence bit reads 0, both clock enables are 1, `fetch_en_n` is 1 and `core_rst` is 0.
- R2: A mode write with data 01 (bit 0 = idle, bit 1 = power down) made while running gives, from the next cycle, mode 01, `cpu_ce`=0, `per_ce`=1, `addr_strobe`=1 and `fetch_en_n`=1.
- R3: A mode write with bit 1 set enters power down even if bit 0 is also set. The mode reads 10, and `cpu_ce`, `per_ce`, `addr_strobe` and `fetch_en_n` are all 0.
- R4: In idle, `irq_pend` high at a clock edge clears the idle bit at that edge, which restores `cpu_ce`.
- R5: `irq_pend` has no effect on the mode while running or in power down.
- R6: Writes to the mode field and to the silence bit take effect only while the mode is 00. In idle or power down they change nothing.
- R7: `core_rst` rises at the 24th consecutive rising edge at which `rst_pin` is sampled high. It stays high while the pin stays high, and falls at the first edge at which the pin is sampled low.
- R8: A pin pulse lasting 23 edges or fewer never raises `core_rst` and leaves the mode and the silence bit unchanged.
- R9: One edge after `core_rst` is seen high, the mode is 00 and the silence bit is 0, whatever writes arrive in that cycle.
- R10: While running with the silence bit 0, `addr_strobe` repeats a six-clock pattern of 2 clocks high then 4 clocks low. The pattern starts high in the first running cycle after reset release.
- R11: The silence bit (written through `cfg_wr`/`cfg_wdata`) holds `addr_strobe` low while running. After it is cleared, the six-clock pattern restarts from its high phase.
- R12: On waking from idle, the strobe pattern restarts from its high phase in the first running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin | input | 1 | External reset pin level, active high |
| irq_pend | input | 1 | An enabled interrupt is pending |
| pwr_wr | input | 1 | Write strobe for the power mode field |
| pwr_wdata | input | 2 | Mode write data: bit 0 idle, bit 1 power down |
| cfg_wr | input | 1 | Write strobe for the strobe-silence bit |
| cfg_wdata | input | 1 | Silence bit write data |
| pwr_mode_q | output | 2 | Current mode field: bit 0 idle, bit 1 power down |
| ale_off_q | output | 1 | Current silence bit |
| cpu_ce | output | 1 | Core clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| addr_strobe | output | 1 | Address latch strobe pin level |
| fetch_en_n | output | 1 | Program fetch enable pin level, active low |
| core_rst | output | 1 | Qualified reset to the rest of the chip |

## Verification
The reset qualifier and the register write path can act at the same clock edge. The bench holds the pin high until `core_rst` is seen high. In that same cycle it issues both a mode write and a silence write, then confirms that both fields read zero afterwards: the reset wins. A second overlap comes from the random phase. There, pulses of random length, some just short of and some just past the 24-edge threshold, are mixed with writes and interrupts in every mode, and each result is compared with a bench model of the mode field.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pmode_e;

    typedef struct packed {
        logic down;
        logic idle;
    } mode_bits_t;

    typedef struct packed {
        logic cpu_ce;
        logic per_ce;
    } clk_en_t;

    typedef struct packed {
        logic strobe;
        logic fetch_n;
    } pin_lvl_t;

    function automatic pmode_e decode_mode(input mode_bits_t b);
        if (b.down)      return PM_DOWN;
        else if (b.idle) return PM_IDLE;
        else             return PM_RUN;
    endfunction

    // Power down dominates when both request bits are set.
    function automatic mode_bits_t resolve_write(input logic [1:0] wd);
        mode_bits_t r;
        r.down = wd[1];
        r.idle = wd[0] & ~wd[1];
        return r;
    endfunction

    function automatic clk_en_t enables_for(input pmode_e m);
        clk_en_t e;
        e.cpu_ce = (m == PM_RUN);
        e.per_ce = (m != PM_DOWN);
        return e;
    endfunction

endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int QUAL_CLKS = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic qual
);
    localparam int CW = $clog2(QUAL_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

    logic [CW-1:0] cnt;
    logic          qual_q;

    always_ff @(posedge clk) begin
        if (rst || !pin) begin
            cnt    <= '0;
            qual_q <= 1'b0;
        end else begin
            if (cnt != LAST) cnt <= cnt + 1'b1;
            qual_q <= (cnt == LAST);
        end
    end

    assign qual = qual_q;
endmodule

// File: rtl/pmc_mode_ctl.sv
module pmc_mode_ctl
    import pmc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         core_rst,
    input  logic         wr,
    input  logic [1:0]   wdata,
    input  logic         irq,
    output mode_bits_t   bits,
    output pmode_e       mode,
    output clk_en_t      en
);
    mode_bits_t bits_q;

    assign mode = decode_mode(bits_q);
    assign en   = enables_for(mode);
    assign bits = bits_q;

    always_ff @(posedge clk) begin
        if (rst || core_rst) begin
            bits_q <= '0;
        end else begin
            unique case (mode)
                PM_RUN:  if (wr)  bits_q <= resolve_write(wdata);
                PM_IDLE: if (irq) bits_q.idle <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pmc_strobe_gen.sv
module pmc_strobe_gen
    import pmc_pkg::*;
#(
    parameter int ALE_DIV  = 6,
    parameter int ALE_HIGH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     core_rst,
    input  pmode_e   mode,
    input  logic     cfg_wr,
    input  logic     cfg_wdata,
    output logic     silence,
    output pin_lvl_t pins
);
    localparam int PW = $clog2(ALE_DIV);
    localparam logic [PW-1:0] PH_LAST = PW'(ALE_DIV - 1);
    localparam logic [PW-1:0] PH_HIGH = PW'(ALE_HIGH);

    logic          run;
    logic          silence_q;
    logic [PW-1:0] phase;

    assign run     = (mode == PM_RUN);
    assign silence = silence_q;

    always_ff @(posedge clk) begin
        if (rst || core_rst)      silence_q <= 1'b0;
        else if (run && cfg_wr)   silence_q <= cfg_wdata;
    end

    // Phase is held at zero whenever the strobe is not toggling, so every
    // return to toggling begins with the high part of the pattern.
    always_ff @(posedge clk) begin
        if (rst || core_rst || !run || silence_q) phase <= '0;
        else if (phase == PH_LAST)                phase <= '0;
        else                                      phase <= phase + 1'b1;
    end

    always_comb begin
        unique case (mode)
            PM_DOWN: pins = '{strobe: 1'b0, fetch_n: 1'b0};
            PM_IDLE: pins = '{strobe: 1'b1, fetch_n: 1'b1};
            default: pins = '{strobe: ~silence_q & (phase < PH_HIGH), fetch_n: 1'b1};
        endcase
    end
endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
    import pmc_pkg::*;
#(
    parameter int OSC_PER_MCYC = 12,
    parameter int RST_MCYC     = 2,
    parameter int ALE_DIV      = 6,
    parameter int ALE_HIGH     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pin,
    input  logic       irq_pend,
    input  logic       pwr_wr,
    input  logic [1:0] pwr_wdata,
    input  logic       cfg_wr,
    input  logic       cfg_wdata,
    output logic [1:0] pwr_mode_q,
    output logic       ale_off_q,
    output logic       cpu_ce,
    output logic       per_ce,
    output logic       addr_strobe,
    output logic       fetch_en_n,
    output logic       core_rst
);
    localparam int QUAL_CLKS = OSC_PER_MCYC * RST_MCYC;

    mode_bits_t bits;
    pmode_e     mode;
    clk_en_t    en;
    pin_lvl_t   pins;
    logic       qual;

    pmc_rst_qual #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
        .clk  (clk),
        .rst  (rst),
        .pin  (rst_pin),
        .qual (qual)
    );

    pmc_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .core_rst (qual),
        .wr       (pwr_wr),
        .wdata    (pwr_wdata),
        .irq      (irq_pend),
        .bits     (bits),
        .mode     (mode),
        .en       (en)
    );

    pmc_strobe_gen #(.ALE_DIV(ALE_DIV), .ALE_HIGH(ALE_HIGH)) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .core_rst  (qual),
        .mode      (mode),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .silence   (ale_off_q),
        .pins      (pins)
    );

    assign pwr_mode_q  = {bits.down, bits.idle};
    assign cpu_ce      = en.cpu_ce;
    assign per_ce      = en.per_ce;
    assign addr_strobe = pins.strobe;
    assign fetch_en_n  = pins.fetch_n;
    assign core_rst    = qual;
endmodule

// File: rtl/pmc_power_ctrl_chk.sv
module pmc_power_ctrl_chk #(
    parameter int OSC_PER_MCYC = 12,
    parameter int RST_MCYC     = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       rst_pin,
    input logic       irq_pend,
    input logic [1:0] pwr_mode_q,
    input logic       ale_off_q,
    input logic       cpu_ce,
    input logic       per_ce,
    input logic       addr_strobe,
    input logic       fetch_en_n,
    input logic       core_rst
);
    localparam int QUAL = OSC_PER_MCYC * RST_MCYC;
    localparam int HW   = $clog2(QUAL + 1);

    logic [HW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rst_pin)           high_cnt <= '0;
        else if (high_cnt != HW'(QUAL)) high_cnt <= high_cnt + 1'b1;
    end

    p_after_por_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwr_mode_q == 2'b00 && !ale_off_q && !core_rst));

    p_idle_pins_r2: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode_q == 2'b01) |-> (!cpu_ce && per_ce && addr_strobe && fetch_en_n));

    p_down_pins_r3: assert property (@(posedge clk) disable iff (rst)
        pwr_mode_q[1] |-> (!cpu_ce && !per_ce && !addr_strobe && !fetch_en_n));

    p_one_mode_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(pwr_mode_q) <= 1);

    p_wake_r4: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode_q == 2'b01 && irq_pend) |=> !pwr_mode_q[0]);

    p_down_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode_q[1] && !core_rst) |=> pwr_mode_q[1]);

    p_qual_window_r7: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (high_cnt >= HW'(QUAL)));

    p_rst_clear_r9: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> (pwr_mode_q == 2'b00 && !ale_off_q));

    p_silence_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode_q == 2'b00 && ale_off_q) |-> !addr_strobe);
endmodule

bind pmc_power_ctrl pmc_power_ctrl_chk #(
    .OSC_PER_MCYC (OSC_PER_MCYC),
    .RST_MCYC     (RST_MCYC)
) u_chk (.*);

// File: tb/sim_pmc_power_ctrl.sv
module sim_pmc_power_ctrl;
    logic       clk = 1'b0;
    logic       rst, rst_pin, irq_pend, pwr_wr, cfg_wr, cfg_wdata;
    logic [1:0] pwr_wdata;
    logic [1:0] pwr_mode_q;
    logic       ale_off_q, cpu_ce, per_ce, addr_strobe, fetch_en_n, core_rst;

    always #4 clk = ~clk;

    pmc_power_ctrl u0 (
        .clk(clk), .rst(rst), .rst_pin(rst_pin), .irq_pend(irq_pend),
        .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .pwr_mode_q(pwr_mode_q), .ale_off_q(ale_off_q), .cpu_ce(cpu_ce), .per_ce(per_ce),
        .addr_strobe(addr_strobe), .fetch_en_n(fetch_en_n), .core_rst(core_rst)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [1:0] m_mode;
    logic       m_off;

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [1:0] model_write(input logic [1:0] cur, input logic [1:0] wd);
        if (cur != 2'b00) return cur;
        if (wd[1])        return 2'b10;
        if (wd[0])        return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic strobe_pat(input int k);
        return (k % 6) < 2;
    endfunction

    task automatic check_static(input string req);
        check(req, "mode", {6'd0, pwr_mode_q}, {6'd0, m_mode});
        check(req, "silence", {7'd0, ale_off_q}, {7'd0, m_off});
        check(req, "cpu_ce", {7'd0, cpu_ce}, {7'd0, m_mode == 2'b00});
        check(req, "per_ce", {7'd0, per_ce}, {7'd0, !m_mode[1]});
        check(req, "fetch_en_n", {7'd0, fetch_en_n}, {7'd0, !m_mode[1]});
        if (m_mode == 2'b01) check(req, "strobe idle", {7'd0, addr_strobe}, 8'd1);
        if (m_mode[1])       check(req, "strobe down", {7'd0, addr_strobe}, 8'd0);
    endtask

    task automatic do_pwr_write(input logic [1:0] wd);
        pwr_wr = 1'b1; pwr_wdata = wd;
        tick();
        pwr_wr = 1'b0;
        m_mode = model_write(m_mode, wd);
    endtask

    task automatic do_cfg_write(input logic b);
        cfg_wr = 1'b1; cfg_wdata = b;
        tick();
        cfg_wr = 1'b0;
        if (m_mode == 2'b00) m_off = b;
    endtask

    task automatic do_irq();
        irq_pend = 1'b1;
        tick();
        irq_pend = 1'b0;
        if (m_mode == 2'b01) m_mode = 2'b00;
    endtask

    task automatic do_pulse(input int n);
        logic early;
        early = 1'b0;
        rst_pin = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick();
            if (i < 23 && core_rst) early = 1'b1;
        end
        check("R8", "no early qualified reset", {7'd0, early}, 8'd0);
        check("R7", "qualified reset at end of pulse", {7'd0, core_rst}, {7'd0, n >= 24});
        rst_pin = 1'b0;
        tick();
        check("R7", "qualified reset falls", {7'd0, core_rst}, 8'd0);
        if (n >= 24) begin
            m_mode = 2'b00;
            m_off  = 1'b0;
        end
    endtask

    task automatic strobe_run(input string req, input int len);
        for (int k = 0; k < len; k++) begin
            check(req, "strobe pattern", {7'd0, addr_strobe}, {7'd0, strobe_pat(k)});
            tick();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1; rst_pin = 1'b0; irq_pend = 1'b0;
        pwr_wr = 1'b0; pwr_wdata = 2'b00; cfg_wr = 1'b0; cfg_wdata = 1'b0;
        m_mode = 2'b00; m_off = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check_static("R1");
        check("R1", "core_rst", {7'd0, core_rst}, 8'd0);

        // Idle entry, ignored write, interrupt wake with strobe restart
        do_pwr_write(2'b01);
        check_static("R2");
        do_pwr_write(2'b10);
        check_static("R6");
        do_irq();
        check_static("R4");
        strobe_run("R12", 12);
        do_irq();
        check_static("R5");

        // Silence bit
        do_cfg_write(1'b1);
        check_static("R11");
        for (int k = 0; k < 8; k++) begin
            check("R11", "strobe silenced", {7'd0, addr_strobe}, 8'd0);
            tick();
        end
        do_cfg_write(1'b0);
        strobe_run("R11", 12);

        // Power down with both bits, sticky against interrupts and writes
        do_pwr_write(2'b11);
        check_static("R3");
        do_irq();
        check_static("R5");
        do_cfg_write(1'b1);
        check_static("R6");
        do_pwr_write(2'b01);
        check_static("R6");
        do_pulse(23);
        check_static("R8");
        do_pulse(24);
        check_static("R9");
        strobe_run("R10", 18);

        // Writes landing in the same cycle as the qualified reset
        do_cfg_write(1'b1);
        rst_pin = 1'b1;
        repeat (24) tick();
        check("R7", "qualified before collision", {7'd0, core_rst}, 8'd1);
        pwr_wr = 1'b1; pwr_wdata = 2'b01; cfg_wr = 1'b1; cfg_wdata = 1'b1;
        tick();
        pwr_wr = 1'b0; cfg_wr = 1'b0;
        check("R9", "mode after collision", {6'd0, pwr_mode_q}, 8'd0);
        check("R9", "silence after collision", {7'd0, ale_off_q}, 8'd0);
        rst_pin = 1'b0;
        tick();
        m_mode = 2'b00; m_off = 1'b0;
        check_static("R9");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: do_pwr_write(2'($urandom));
                1: do_cfg_write(1'($urandom));
                2: do_irq();
                3: do_pulse(1 + int'($urandom % 23));
                default: do_pulse(24 + int'($urandom % 8));
            endcase
            check_static("R6");
        end

        summary();
    end
endmodule